// File: doc/BRIEF.md
# Ethernet MAC interrupt event register

This block collects the single-cycle event pulses raised by a 10/100 Ethernet MAC's transmit, receive, DMA and management paths. It holds each one as a sticky status flag in a 32-bit event register. Software reads the event register and acknowledges flags by writing ones to them. A second 32-bit register with the same bit layout selects which flags drive the interrupt line. The single interrupt output is the registered OR of the enabled flags.

Some events are derived inside the block from raw MAC signals rather than taken as ready-made pulses. The stop-complete flag merges three stop origins. Descriptor updates are split into buffer and frame events depending on whether the descriptor is the last of its frame. The babble events come from comparing a frame length with the programmed maximum. The heartbeat event comes from watching the collision input across the heartbeat window. The block also owns the MAC enable bit. A bus error event clears that bit on the same clock edge that records the error, which halts frame processing.

The register port accepts one request per cycle and has no back-pressure. A read returns its data one cycle after the request, marked by `rsp_valid`. Writes take effect on the request's clock edge.

Top module: `emac_irq_events`

## Requirements
- R1: The event register sits at offset 0x04. Its flags occupy bits 31 down to 19 in this order: heartbeat error (31), babbling receive (30), babbling transmit (29), stop complete (28), transmit frame (27), transmit buffer (26), receive frame (25), receive buffer (24), management transfer done (23), bus error (22), late collision (21), retry limit (20), underrun (19).
- R2: Bits 18 down to 0 of both the event and the enable register always read as zero, and writes to them have no effect.
- R3: All flags reset to zero. A flag, once set, stays set until software writes a one to its bit at offset 0x04. Writing a zero leaves the flag unchanged.
- R4: When an event and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.
- R5: `mac_en` resets to 0 and is set by a `mac_en_set` pulse. A bus error pulse sets flag 22 and forces `mac_en` to 0 on the same edge, even when `mac_en_set` is high in that cycle.
- R6: Flag 28 is set by completion of any of these: a software transmit stop, a software pause-frame transmit, or a received full-duplex pause frame.
- R7: On a receive descriptor update, flag 25 is set if the descriptor is the last of its frame, and flag 24 is set otherwise. On a transmit descriptor update, flag 26 is set, and flag 27 is also set if the descriptor is the last.
- R8: A valid receive (transmit) length strictly greater than `max_frame_len` sets flag 30 (29). A length equal to the maximum does not set it.
- R9: While `hb_check_en` is high, flag 31 is set in the cycle after `hb_window` falls if `col_in` was low in every cycle that `hb_window` was high. With checking disabled, or if a collision was seen in the window, flag 31 is not set.
- R10: The enable register at offset 0x08 resets to zero. `irq` is high in the cycle after the event register ANDed with the enable register is non-zero, and low in the cycle after it is zero.
- R11: A read request produces `rsp_valid` on the next cycle, with the register contents as they stood at the request. Reads of any offset other than 0x04 and 0x08 return zero, and writes to such an offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request, one per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| hb_check_en | input | 1 | Heartbeat checking enabled |
| hb_window | input | 1 | High during the heartbeat window after a transmission |
| col_in | input | 1 | Collision input |
| rx_len_valid | input | 1 | Pulse: received frame length is valid |
| rx_len | input | LEN_W | Received frame length in bytes |
| tx_len_valid | input | 1 | Pulse: transmitted frame length is valid |
| tx_len | input | LEN_W | Transmitted frame length in bytes |
| max_frame_len | input | LEN_W | Programmed maximum frame length |
| sw_stop_done | input | 1 | Pulse: software transmit stop complete |
| sw_pause_done | input | 1 | Pulse: software pause-frame transmit complete |
| rx_pause_done | input | 1 | Pulse: stop from a received pause frame complete |
| tx_desc_upd | input | 1 | Pulse: transmit descriptor updated |
| tx_desc_last | input | 1 | That transmit descriptor ends its frame |
| rx_desc_upd | input | 1 | Pulse: receive descriptor updated |
| rx_desc_last | input | 1 | That receive descriptor ends its frame |
| mgmt_done | input | 1 | Pulse: management transfer done |
| bus_err | input | 1 | Pulse: system bus error during DMA |
| late_col | input | 1 | Pulse: late collision |
| retry_limit | input | 1 | Pulse: retry limit reached |
| tx_underrun | input | 1 | Pulse: transmit underrun |
| mac_en_set | input | 1 | Pulse: software enables the MAC |
| mac_en | output | 1 | MAC enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle. Set flags persist unless cleared, and an incoming event is never lost to a simultaneous clear. A bus error drops `mac_en` and records flag 22 together. Each stop origin reaches flag 28. `irq` follows the enabled flags one cycle later, and reserved bits read as zero. Other behaviour can only be shown by the bench's scenarios against its model: the exact bit position of every source, the last/not-last descriptor split, the boundary of the length comparison, the heartbeat window with and without a collision, and what reads and writes to unmapped offsets do.

// File: rtl/emac_irq_pkg.sv
package emac_irq_pkg;
  localparam int REG_W = 32;
  typedef logic [REG_W-1:0] reg_t;

  localparam int B_HB    = 31;
  localparam int B_BABR  = 30;
  localparam int B_BABT  = 29;
  localparam int B_STOP  = 28;
  localparam int B_TXF   = 27;
  localparam int B_TXB   = 26;
  localparam int B_RXF   = 25;
  localparam int B_RXB   = 24;
  localparam int B_MGMT  = 23;
  localparam int B_BERR  = 22;
  localparam int B_LCOL  = 21;
  localparam int B_RLIM  = 20;
  localparam int B_UNDR  = 19;
  localparam int EVT_LO  = B_UNDR;

  // implemented flag bits: EVT_LO .. REG_W-1
  localparam reg_t EVT_MASK = ~((reg_t'(1) << EVT_LO) - reg_t'(1));
endpackage

// File: rtl/emac_irq_src.sv
module emac_irq_src
  import emac_irq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hb_check_en,
  input  logic             hb_window,
  input  logic             col_in,
  input  logic             rx_len_valid,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             tx_len_valid,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] max_frame_len,
  input  logic             sw_stop_done,
  input  logic             sw_pause_done,
  input  logic             rx_pause_done,
  input  logic             tx_desc_upd,
  input  logic             tx_desc_last,
  input  logic             rx_desc_upd,
  input  logic             rx_desc_last,
  input  logic             mgmt_done,
  input  logic             bus_err,
  input  logic             late_col,
  input  logic             retry_limit,
  input  logic             tx_underrun,
  output reg_t             evt
);
  // Heartbeat window tracking
  logic win_q;
  logic col_seen_q;
  logic win_open;
  logic win_close;

  assign win_open  = hb_window & ~win_q;
  assign win_close = win_q & ~hb_window;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q      <= 1'b0;
      col_seen_q <= 1'b0;
    end else begin
      win_q <= hb_window;
      if (win_open)
        col_seen_q <= col_in;
      else if (hb_window)
        col_seen_q <= col_seen_q | col_in;
    end
  end

  logic hb_evt;
  assign hb_evt = hb_check_en & win_close & ~col_seen_q;

  // Length comparisons
  logic rx_babble;
  logic tx_babble;
  assign rx_babble = rx_len_valid & (rx_len > max_frame_len);
  assign tx_babble = tx_len_valid & (tx_len > max_frame_len);

  always_comb begin
    evt          = '0;
    evt[B_HB]    = hb_evt;
    evt[B_BABR]  = rx_babble;
    evt[B_BABT]  = tx_babble;
    evt[B_STOP]  = sw_stop_done | sw_pause_done | rx_pause_done;
    evt[B_TXF]   = tx_desc_upd & tx_desc_last;
    evt[B_TXB]   = tx_desc_upd;
    evt[B_RXF]   = rx_desc_upd & rx_desc_last;
    evt[B_RXB]   = rx_desc_upd & ~rx_desc_last;
    evt[B_MGMT]  = mgmt_done;
    evt[B_BERR]  = bus_err;
    evt[B_LCOL]  = late_col;
    evt[B_RLIM]  = retry_limit;
    evt[B_UNDR]  = tx_underrun;
  end
endmodule

// File: rtl/emac_irq_regs.sv
module emac_irq_regs
  import emac_irq_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] EVT_OFS = 8'h04,
  parameter logic [ADDR_W-1:0] ENA_OFS = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  reg_t              req_wdata,
  input  reg_t              evt,
  output reg_t              st_q,
  output reg_t              msk_q,
  output reg_t              w1c_bits,
  output logic              rsp_valid,
  output reg_t              rsp_rdata
);
  logic hit_evt;
  logic hit_ena;
  logic wr_ena;
  reg_t st_nxt;
  reg_t rd_sel;

  assign hit_evt  = (req_addr == EVT_OFS);
  assign hit_ena  = (req_addr == ENA_OFS);
  assign wr_ena   = req_valid & req_write & hit_ena;
  assign w1c_bits = (req_valid & req_write & hit_evt) ? (req_wdata & EVT_MASK) : '0;

  // Per-bit next state: new event wins over clear
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (EVT_MASK[i]) begin : g_flag
      assign st_nxt[i] = evt[i] | (st_q[i] & ~w1c_bits[i]);
    end else begin : g_rsv
      assign st_nxt[i] = 1'b0;
    end
  end

  always_comb begin
    if (hit_evt)      rd_sel = st_q;
    else if (hit_ena) rd_sel = msk_q;
    else              rd_sel = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= '0;
      msk_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      st_q      <= st_nxt;
      if (wr_ena)
        msk_q <= req_wdata & EVT_MASK;
      rsp_valid <= req_valid & ~req_write;
      if (req_valid & ~req_write)
        rsp_rdata <= rd_sel;
    end
  end
endmodule

// File: rtl/emac_irq_ctrl.sv
module emac_irq_ctrl
  import emac_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  reg_t st_q,
  input  reg_t msk_q,
  input  logic berr_evt,
  input  logic mac_en_set,
  output logic mac_en,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mac_en <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (berr_evt)
        mac_en <= 1'b0;
      else if (mac_en_set)
        mac_en <= 1'b1;
      irq <= |(st_q & msk_q);
    end
  end
endmodule

// File: rtl/emac_irq_events.sv
module emac_irq_events
  import emac_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              hb_check_en,
  input  logic              hb_window,
  input  logic              col_in,
  input  logic              rx_len_valid,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              tx_len_valid,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [LEN_W-1:0]  max_frame_len,
  input  logic              sw_stop_done,
  input  logic              sw_pause_done,
  input  logic              rx_pause_done,
  input  logic              tx_desc_upd,
  input  logic              tx_desc_last,
  input  logic              rx_desc_upd,
  input  logic              rx_desc_last,
  input  logic              mgmt_done,
  input  logic              bus_err,
  input  logic              late_col,
  input  logic              retry_limit,
  input  logic              tx_underrun,
  input  logic              mac_en_set,
  output logic              mac_en,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] EVT_OFS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ENA_OFS = ADDR_W'(8);

  reg_t evt_vec;
  reg_t st_q;
  reg_t msk_q;
  reg_t w1c_bits;

  emac_irq_src #(.LEN_W(LEN_W)) u_src (
    .clk           (clk),
    .rst_n         (rst_n),
    .hb_check_en   (hb_check_en),
    .hb_window     (hb_window),
    .col_in        (col_in),
    .rx_len_valid  (rx_len_valid),
    .rx_len        (rx_len),
    .tx_len_valid  (tx_len_valid),
    .tx_len        (tx_len),
    .max_frame_len (max_frame_len),
    .sw_stop_done  (sw_stop_done),
    .sw_pause_done (sw_pause_done),
    .rx_pause_done (rx_pause_done),
    .tx_desc_upd   (tx_desc_upd),
    .tx_desc_last  (tx_desc_last),
    .rx_desc_upd   (rx_desc_upd),
    .rx_desc_last  (rx_desc_last),
    .mgmt_done     (mgmt_done),
    .bus_err       (bus_err),
    .late_col      (late_col),
    .retry_limit   (retry_limit),
    .tx_underrun   (tx_underrun),
    .evt           (evt_vec)
  );

  emac_irq_regs #(
    .ADDR_W  (ADDR_W),
    .EVT_OFS (EVT_OFS),
    .ENA_OFS (ENA_OFS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .evt       (evt_vec),
    .st_q      (st_q),
    .msk_q     (msk_q),
    .w1c_bits  (w1c_bits),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  emac_irq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_q       (st_q),
    .msk_q      (msk_q),
    .berr_evt   (evt_vec[B_BERR]),
    .mac_en_set (mac_en_set),
    .mac_en     (mac_en),
    .irq        (irq)
  );
endmodule

// File: rtl/emac_irq_chk.sv
module emac_irq_chk
  import emac_irq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input reg_t        evt_vec,
  input reg_t        st_q,
  input reg_t        msk_q,
  input reg_t        w1c_bits,
  input logic        irq,
  input logic        mac_en,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        sw_stop_done,
  input logic        sw_pause_done,
  input logic        rx_pause_done
);
  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(st_q) & ~$past(w1c_bits) & ~st_q) == '0));

  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_vec) & ~st_q) == '0));

  // R5
  berr_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vec[B_BERR] |=> (!mac_en && st_q[B_BERR]));

  // R6
  stop_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stop_done || sw_pause_done || rx_pause_done) |=> st_q[B_STOP]);

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & msk_q) != '0) |=> irq);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |=> !irq);

  // R2
  rsv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[EVT_LO-1:0] == '0));

  // R2
  rsv_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q | msk_q) & ~EVT_MASK) == '0);
endmodule

bind emac_irq_events emac_irq_chk u_chk (.*);

// File: tb/emac_irq_events_bench.sv
module emac_irq_events_bench;
  localparam logic [31:0] IMPL = 32'hFFF8_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        hb_check_en = 0, hb_window = 0, col_in = 0;
  logic        rx_len_valid = 0, tx_len_valid = 0;
  logic [15:0] rx_len = 0, tx_len = 0, max_frame_len = 16'd1518;
  logic        sw_stop_done = 0, sw_pause_done = 0, rx_pause_done = 0;
  logic        tx_desc_upd = 0, tx_desc_last = 0, rx_desc_upd = 0, rx_desc_last = 0;
  logic        mgmt_done = 0, bus_err = 0, late_col = 0, retry_limit = 0, tx_underrun = 0;
  logic        mac_en_set = 0, mac_en, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [31:0] m_st = 0, m_msk = 0;
  logic        m_mac = 0, m_win = 0, m_col = 0;

  always #5 clk = ~clk;

  emac_irq_events u_emac_irq_events (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_evt();
    logic [31:0] e = 0;
    e[31] = hb_check_en && m_win && !hb_window && !m_col;
    e[30] = rx_len_valid && (rx_len > max_frame_len);
    e[29] = tx_len_valid && (tx_len > max_frame_len);
    e[28] = sw_stop_done || sw_pause_done || rx_pause_done;
    e[27] = tx_desc_upd && tx_desc_last;
    e[26] = tx_desc_upd;
    e[25] = rx_desc_upd && rx_desc_last;
    e[24] = rx_desc_upd && !rx_desc_last;
    e[23] = mgmt_done;
    e[22] = bus_err;
    e[21] = late_col;
    e[20] = retry_limit;
    e[19] = tx_underrun;
    return e;
  endfunction

  task automatic clear_pulses();
    req_valid = 0; req_write = 0;
    rx_len_valid = 0; tx_len_valid = 0;
    sw_stop_done = 0; sw_pause_done = 0; rx_pause_done = 0;
    tx_desc_upd = 0; tx_desc_last = 0; rx_desc_upd = 0; rx_desc_last = 0;
    mgmt_done = 0; bus_err = 0; late_col = 0; retry_limit = 0; tx_underrun = 0;
    mac_en_set = 0;
  endtask

  // One clock: predict, step, compare, update model
  task automatic cyc();
    logic [31:0] ev, pre_st, pre_msk, clr, exp_rd;
    logic rd;
    ev = model_evt();
    pre_st = m_st; pre_msk = m_msk;
    clr = (req_valid && req_write && req_addr == 8'h04) ? (req_wdata & IMPL) : 32'h0;
    rd = req_valid && !req_write;
    exp_rd = (req_addr == 8'h04) ? pre_st : (req_addr == 8'h08) ? pre_msk : 32'h0;
    @(posedge clk); #1;
    m_st = (pre_st & ~clr) | ev;
    if (req_valid && req_write && req_addr == 8'h08) m_msk = req_wdata & IMPL;
    if (bus_err) m_mac = 0; else if (mac_en_set) m_mac = 1;
    if (hb_window) m_col = m_win ? (m_col | col_in) : col_in;
    m_win = hb_window;
    chk(irq == |(pre_st & pre_msk), "R10 irq", {31'h0, irq}, {31'h0, |(pre_st & pre_msk)});
    chk(mac_en == m_mac, "R5 mac_en", {31'h0, mac_en}, {31'h0, m_mac});
    chk(rsp_valid == rd, "R11 rsp_valid", {31'h0, rsp_valid}, {31'h0, rd});
    if (rd) chk(rsp_rdata == exp_rd, "R1 R11 read data", rsp_rdata, exp_rd);
    clear_pulses();
  endtask

  task automatic rd_reg(input logic [7:0] a);
    req_valid = 1; req_write = 0; req_addr = a; cyc();
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; cyc();
  endtask

  task automatic expect_st(input logic [31:0] e, input string tag);
    rd_reg(8'h04);
    chk(rsp_rdata == e, tag, rsp_rdata, e);
  endtask

  task automatic drive_src(input int i);
    case (i)
      0: begin rx_len_valid = 1; rx_len = max_frame_len + 16'd5; end
      1: begin tx_len_valid = 1; tx_len = max_frame_len + 16'd5; end
      2: sw_stop_done = 1;
      3: begin tx_desc_upd = 1; tx_desc_last = 1; end
      4: tx_desc_upd = 1;
      5: begin rx_desc_upd = 1; rx_desc_last = 1; end
      6: rx_desc_upd = 1;
      7: mgmt_done = 1;
      8: bus_err = 1;
      9: late_col = 1;
      10: retry_limit = 1;
      default: tx_underrun = 1;
    endcase
  endtask

  function automatic logic [31:0] src_bits(input int i);
    case (i)
      0: return 32'h4000_0000;
      1: return 32'h2000_0000;
      2: return 32'h1000_0000;
      3: return 32'h0C00_0000;
      4: return 32'h0400_0000;
      5: return 32'h0200_0000;
      6: return 32'h0100_0000;
      7: return 32'h0080_0000;
      8: return 32'h0040_0000;
      9: return 32'h0020_0000;
      10: return 32'h0010_0000;
      default: return 32'h0008_0000;
    endcase
  endfunction

  task automatic hb_run(input bit en, input bit with_col);
    hb_check_en = en;
    hb_window = 1; cyc();
    col_in = with_col; cyc();
    col_in = 0; cyc();
    hb_window = 0; cyc();
    cyc();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R3 reset state
    chk(irq == 0 && mac_en == 0, "R3 reset outputs", {30'h0, irq, mac_en}, 32'h0);
    expect_st(32'h0, "R3 reset event reg");
    rd_reg(8'h08);
    chk(rsp_rdata == 0, "R10 reset enable reg", rsp_rdata, 32'h0);

    // R1 R7 R8 bit position of every source
    for (int i = 0; i < 12; i++) begin
      drive_src(i); cyc();
      expect_st(src_bits(i), "R1 R7 source bit");
      wr_reg(8'h04, 32'hFFFF_FFFF);
      expect_st(32'h0, "R3 clear all");
    end

    // R3 partial clear and zero write
    late_col = 1; mgmt_done = 1; cyc();
    wr_reg(8'h04, 32'h0000_0000);
    expect_st(32'h00A0_0000, "R3 zero write keeps flags");
    wr_reg(8'h04, 32'h0020_0000);
    expect_st(32'h0080_0000, "R3 single clear");
    // R4 event and clear same cycle
    mgmt_done = 1; req_valid = 1; req_write = 1; req_addr = 8'h04; req_wdata = 32'h0080_0000; cyc();
    expect_st(32'h0080_0000, "R4 event beats clear");
    wr_reg(8'h04, 32'hFFFF_FFFF);

    // R2 reserved bits
    wr_reg(8'h08, 32'hFFFF_FFFF);
    rd_reg(8'h08);
    chk(rsp_rdata == IMPL, "R2 enable reserved bits", rsp_rdata, IMPL);
    wr_reg(8'h08, 32'h0);

    // R10 irq masking
    retry_limit = 1; cyc(); cyc();
    chk(irq == 0, "R10 masked flag no irq", {31'h0, irq}, 32'h0);
    wr_reg(8'h08, 32'h0010_0000); cyc();
    chk(irq == 1, "R10 enabled flag irq", {31'h0, irq}, 32'h1);
    wr_reg(8'h04, 32'h0010_0000); cyc();
    chk(irq == 0, "R10 irq drops after clear", {31'h0, irq}, 32'h0);
    wr_reg(8'h08, 32'h0);

    // R5 bus error beats enable request
    mac_en_set = 1; cyc();
    chk(mac_en == 1, "R5 enable set", {31'h0, mac_en}, 32'h1);
    bus_err = 1; mac_en_set = 1; cyc();
    chk(mac_en == 0, "R5 bus error clears enable", {31'h0, mac_en}, 32'h0);
    wr_reg(8'h04, 32'hFFFF_FFFF);

    // R6 all three stop origins
    sw_pause_done = 1; cyc();
    expect_st(32'h1000_0000, "R6 pause transmit stop");
    wr_reg(8'h04, 32'hFFFF_FFFF);
    rx_pause_done = 1; cyc();
    expect_st(32'h1000_0000, "R6 received pause stop");
    wr_reg(8'h04, 32'hFFFF_FFFF);

    // R8 boundary
    rx_len_valid = 1; rx_len = max_frame_len; tx_len_valid = 1; tx_len = max_frame_len; cyc();
    expect_st(32'h0, "R8 equal length no babble");
    tx_len_valid = 1; tx_len = max_frame_len + 16'd1; cyc();
    expect_st(32'h2000_0000, "R8 one over");
    wr_reg(8'h04, 32'hFFFF_FFFF);

    // R9 heartbeat
    hb_run(1, 0);
    expect_st(32'h8000_0000, "R9 no collision in window");
    wr_reg(8'h04, 32'hFFFF_FFFF);
    hb_run(1, 1);
    expect_st(32'h0, "R9 collision seen");
    hb_run(0, 0);
    expect_st(32'h0, "R9 checking disabled");

    // R11 unmapped offset
    wr_reg(8'h0C, 32'hFFFF_FFFF);
    rd_reg(8'h0C);
    chk(rsp_rdata == 0, "R11 unmapped read", rsp_rdata, 32'h0);
    rd_reg(8'h08);
    chk(rsp_rdata == 0, "R11 unmapped write ignored", rsp_rdata, 32'h0);

    // Random mix against the model
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r < 12) drive_src(r);
      if ($urandom_range(0, 3) == 0) drive_src($urandom_range(0, 11));
      if ($urandom_range(0, 7) == 0) rx_pause_done = 1;
      if ($urandom_range(0, 9) == 0) mac_en_set = 1;
      if ($urandom_range(0, 5) == 0) begin rx_len_valid = 1; rx_len = max_frame_len - 16'd2 + 16'($urandom_range(0, 4)); end
      hb_check_en = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 4) == 0) hb_window = ~hb_window;
      col_in = ($urandom_range(0, 5) == 0);
      case ($urandom_range(0, 5))
        0: begin req_valid = 1; req_write = 0; req_addr = 8'h04; end
        1: begin req_valid = 1; req_write = 0; req_addr = 8'h08; end
        2: begin req_valid = 1; req_write = 1; req_addr = 8'h04; req_wdata = $urandom; end
        3: begin req_valid = 1; req_write = 1; req_addr = 8'h08; req_wdata = $urandom; end
        4: begin req_valid = 1; req_write = $urandom_range(0, 1) == 1; req_addr = 8'h00; req_wdata = $urandom; end
        default: ;
      endcase
      cyc();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule